// File: doc/BRIEF.md
# System Control Register Bank

This block is a bank of 82 32-bit control and status words reached over a simple single-cycle register bus. Each access presents a byte address, a select and a write enable in one cycle. The bus is always ready. Read data comes back combinationally in that same cycle. A write is committed at the clock edge that closes the access.

Each word has one of four access behaviours. A plain word takes the written value. A read-only word keeps its content. A clear-on-one word drops every bit that is written as one. A set-on-one word gains every bit that is written as one, and only reset removes them. Most words come out of reset with fixed constants. Three come from outside the bank: the power-on strap word and the disabled-module mask are sampled from input buses, and the memory configuration word encodes the DRAM size chosen at build time. Accesses that fall outside the window, that are not word aligned, or that try to write a read-only word raise an error flag for that cycle.

Top module: `sysctl_regbank`

## Requirements
- R1: While rst_n is low at a clock edge, the fixed reset values are loaded. Reading after reset returns: 0x000=0x04A92750, 0x014=0x0000FFFF, 0x038=0x00000003, 0x03C=0x0000035E, 0x050=0x0000004E, 0x060=0x00080000, 0x06C=0x80000000, 0x078=0x000000C0, 0x098=0x5A00F3CF, 0x13C=0x00000008, 0x140=0x034730E4 and 0x144=0x034730E4. Every other word not named in R2 or R3 reads zero.
- R2: At reset, the word at 0x004 takes the value on strap_in and the word at 0x07C takes the value on mod_dis_in. Changing either input after reset has no effect on the stored words.
- R3: At reset, the word at 0x09C takes 0x00001002 OR ((DRAM_LOG2 - 27) << 8), so bits [10:8] hold log2(size / 128 MiB). DRAM_LOG2 must lie in 27..31, and any other value stops elaboration. With the default of 28 the word reads 0x00001102.
- R4: A write to a plain word stores wdata. A read in a later cycle returns that value with err low.
- R5: The words at 0x000, 0x004 and 0x040 are read-only. A write to them leaves the content unchanged and raises err in the access cycle.
- R6: The words at 0x06C and 0x0D4 clear on one: the new value is old AND NOT wdata.
- R7: The words at 0x070 and 0x07C set on one: the new value is old OR wdata. Only reset clears them.
- R8: An aligned access at byte address 0x148 or above reads zero and raises err. A write there changes no word.
- R9: An access whose addr[1:0] is not zero reads zero and raises err. A write there changes no word.
- R10: ready is high in every cycle, including cycles with an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low cold reset |
| sel | input | 1 | Access phase valid |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte address in the 4 KiB region |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the read cycle |
| ready | output | 1 | Always high |
| err | output | 1 | Error flag for the current access |
| strap_in | input | 32 | Power-on strap value sampled at reset |
| mod_dis_in | input | 32 | Disabled-module mask sampled at reset |

## Verification
The checker assumes that strap_in and mod_dis_in stay constant during the last reset cycle before rst_n rises. It also assumes that rst_n never falls in the cycle straight after a write, because a reset there would hide the write effect that the property expects. The stimulus changes the strap buses only while the bank is in reset or well after release, and it deasserts sel before it asserts reset again. Every access lasts exactly one cycle, and each access is driven at a falling edge so that the combinational read path and the error flag settle before they are sampled.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_WORDS = 82;
    localparam int ADDR_W    = 12;
    localparam int IDX_W     = $clog2(NUM_WORDS);
    localparam int WORD_W    = ADDR_W - 2;

    // word indices whose behaviour is special
    localparam int W_ID        = 0;
    localparam int W_STRAP     = 1;
    localparam int W_IRQ_STAT  = 16;
    localparam int W_RST_STAT  = 27;
    localparam int W_RST_LOCK  = 28;
    localparam int W_MOD_DIS   = 31;
    localparam int W_MEM_CFG   = 39;
    localparam int W_HOST_STAT = 53;

    localparam int MEM_LOG2_MIN = 27;
    localparam int MEM_LOG2_MAX = 31;
    localparam int MEM_FIELD_LSB = 8;

    typedef enum logic [1:0] {
        ACC_RW  = 2'd0,
        ACC_RO  = 2'd1,
        ACC_W1C = 2'd2,
        ACC_W1S = 2'd3
    } acc_e;

    typedef struct packed {
        logic [NUM_WORDS-1:0][DATA_W-1:0] regs;
    } bank_t;

    function automatic acc_e acc_of(input int idx);
        case (idx)
            W_ID, W_STRAP, W_IRQ_STAT: return ACC_RO;
            W_RST_STAT, W_HOST_STAT:   return ACC_W1C;
            W_RST_LOCK, W_MOD_DIS:     return ACC_W1S;
            default:                   return ACC_RW;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] fixed_rst(input int idx);
        case (idx)
            0:       return 32'h04A9_2750;
            5:       return 32'h0000_FFFF;
            14:      return 32'h0000_0003;
            15:      return 32'h0000_035E;
            20:      return 32'h0000_004E;
            24:      return 32'h0008_0000;
            27:      return 32'h8000_0000;
            30:      return 32'h0000_00C0;
            38:      return 32'h5A00_F3CF;
            39:      return 32'h0000_1002;
            79:      return 32'h0000_0008;
            80, 81:  return 32'h0347_30E4;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic              sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_rd,
    output logic              hit_wr,
    output logic [IDX_W-1:0]  idx,
    output logic              err
);

    logic [WORD_W-1:0] word;
    logic              in_win;
    logic              aligned;
    logic              valid;
    logic              ro;

    always_comb begin
        word    = addr[ADDR_W-1:2];
        in_win  = word < WORD_W'(NUM_WORDS);
        aligned = (addr[1:0] == 2'b00);
        valid   = in_win && aligned;
        idx     = valid ? word[IDX_W-1:0] : '0;
        ro      = valid && (acc_of(int'(idx)) == ACC_RO);
        hit_rd  = sel && !wr_en && valid;
        hit_wr  = sel && wr_en && valid && !ro;
        err     = sel && (!valid || (wr_en && ro));
    end

endmodule

// File: rtl/sysctl_rstval.sv
module sysctl_rstval
    import sysctl_pkg::*;
#(
    parameter int DRAM_LOG2 = 28
) (
    input  logic [DATA_W-1:0] strap_in,
    input  logic [DATA_W-1:0] mod_dis_in,
    output bank_t             rst_bank
);

    localparam logic [2:0] MEM_CODE = 3'(DRAM_LOG2 - MEM_LOG2_MIN);

    if (DRAM_LOG2 < MEM_LOG2_MIN || DRAM_LOG2 > MEM_LOG2_MAX) begin : g_bad_size
        $error("sysctl_rstval: DRAM_LOG2 out of range 27..31");
    end

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_rst
        if (i == W_STRAP) begin : g_strap
            assign rst_bank.regs[i] = strap_in;
        end else if (i == W_MOD_DIS) begin : g_moddis
            assign rst_bank.regs[i] = mod_dis_in;
        end else if (i == W_MEM_CFG) begin : g_mem
            assign rst_bank.regs[i] = fixed_rst(i)
                                    | (DATA_W'(MEM_CODE) << MEM_FIELD_LSB);
        end else begin : g_const
            assign rst_bank.regs[i] = fixed_rst(i);
        end
    end

endmodule

// File: rtl/sysctl_wmerge.sv
module sysctl_wmerge
    import sysctl_pkg::*;
#(
    parameter acc_e ACC = ACC_RW
) (
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    output logic [DATA_W-1:0] new_val
);

    always_comb begin
        new_val = old_val;
        if (we) begin
            case (ACC)
                ACC_RW:  new_val = wdata;
                ACC_W1C: new_val = old_val & ~wdata;
                ACC_W1S: new_val = old_val | wdata;
                default: new_val = old_val;
            endcase
        end
    end

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int DRAM_LOG2 = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ready,
    output logic              err,
    input  logic [DATA_W-1:0] strap_in,
    input  logic [DATA_W-1:0] mod_dis_in
);

    bank_t st_d, st_q;
    bank_t rst_bank;

    logic             hit_rd;
    logic             hit_wr;
    logic [IDX_W-1:0] idx;

    logic [NUM_WORDS-1:0][DATA_W-1:0] merged;
    logic [NUM_WORDS-1:0][DATA_W-1:0] regs_view;

    sysctl_decode u_decode (
        .sel    (sel),
        .wr_en  (wr_en),
        .addr   (addr),
        .hit_rd (hit_rd),
        .hit_wr (hit_wr),
        .idx    (idx),
        .err    (err)
    );

    sysctl_rstval #(
        .DRAM_LOG2 (DRAM_LOG2)
    ) u_rstval (
        .strap_in   (strap_in),
        .mod_dis_in (mod_dis_in),
        .rst_bank   (rst_bank)
    );

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        sysctl_wmerge #(
            .ACC (acc_of(i))
        ) u_merge (
            .old_val (st_q.regs[i]),
            .wdata   (wdata),
            .we      (hit_wr && (idx == IDX_W'(i))),
            .new_val (merged[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d = rst_bank;
        end else begin
            st_d.regs = merged;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rdata     = hit_rd ? st_q.regs[idx] : '0;
    assign ready     = 1'b1;
    assign regs_view = st_q.regs;

endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk
    import sysctl_pkg::*;
#(
    parameter int DRAM_LOG2 = 28
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             sel,
    input logic                             wr_en,
    input logic [ADDR_W-1:0]                addr,
    input logic [DATA_W-1:0]                wdata,
    input logic [DATA_W-1:0]                rdata,
    input logic                             err,
    input logic [DATA_W-1:0]                strap_in,
    input logic [DATA_W-1:0]                mod_dis_in,
    input logic [NUM_WORDS-1:0][DATA_W-1:0] regs
);

    localparam logic [ADDR_W-1:0] WIN_END = ADDR_W'(NUM_WORDS * 4);

    assert_strap_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (regs[W_STRAP] == $past(strap_in))
                      && (regs[W_MOD_DIS] == $past(mod_dis_in)));

    assert_mem_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> regs[W_MEM_CFG][10:8] == 3'(DRAM_LOG2 - MEM_LOG2_MIN));

    assert_ro_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en && addr == 12'h000) |=> regs[W_ID] == $past(regs[W_ID]));

    assert_ro_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en && (addr == 12'h004 || addr == 12'h040)) |-> err);

    assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en && addr == 12'h06C)
        |=> regs[W_RST_STAT] == ($past(regs[W_RST_STAT]) & ~$past(wdata)));

    assert_w1s_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en && addr == 12'h070)
        |=> (($past(regs[W_RST_LOCK]) & ~regs[W_RST_LOCK]) == '0)
         && ((regs[W_RST_LOCK] & $past(wdata)) == $past(wdata)));

    assert_oor_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && addr >= WIN_END) |-> (rdata == '0) && err);

    assert_oor_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en && addr >= WIN_END) |=> $stable(regs));

    assert_misalign_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && addr[1:0] != 2'b00) |-> err && (rdata == '0));

    assert_misalign_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en && addr[1:0] != 2'b00) |=> $stable(regs));

endmodule

bind sysctl_regbank sysctl_regbank_chk #(
    .DRAM_LOG2 (DRAM_LOG2)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .err        (err),
    .strap_in   (strap_in),
    .mod_dis_in (mod_dis_in),
    .regs       (regs_view)
);

// File: tb/sysctl_regbank_bench.sv
module sysctl_regbank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ready;
    logic        err;
    logic [31:0] strap_in = 32'hA5C3_0F17;
    logic [31:0] mod_dis_in = 32'h0000_1230;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sysctl_regbank u_sysctl_regbank (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .ready      (ready),
        .err        (err),
        .strap_in   (strap_in),
        .mod_dis_in (mod_dis_in)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b0; addr = a;
        #1;
        d = rdata; e = err;
        @(posedge clk);
        #1;
        sel = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v, output logic e);
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b1; addr = a; wdata = v;
        #1;
        e = err;
        @(posedge clk);
        #1;
        sel = 1'b0; wr_en = 1'b0;
    endtask

    task automatic expect_rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        logic e;
        rd(a, d, e);
        chk(req, d, exp);
        chk({req, " err"}, {31'd0, e}, 32'd0);
    endtask

    task automatic do_reset(input logic [31:0] s, input logic [31:0] m);
        @(negedge clk);
        rst_n = 1'b0; strap_in = s; mod_dis_in = m;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_values;
        expect_rd("R1 id",      12'h000, 32'h04A9_2750);
        expect_rd("R1 0x014",   12'h014, 32'h0000_FFFF);
        expect_rd("R1 0x038",   12'h038, 32'h0000_0003);
        expect_rd("R1 0x03C",   12'h03C, 32'h0000_035E);
        expect_rd("R1 0x050",   12'h050, 32'h0000_004E);
        expect_rd("R1 0x060",   12'h060, 32'h0008_0000);
        expect_rd("R1 0x06C",   12'h06C, 32'h8000_0000);
        expect_rd("R1 0x078",   12'h078, 32'h0000_00C0);
        expect_rd("R1 0x098",   12'h098, 32'h5A00_F3CF);
        expect_rd("R1 0x13C",   12'h13C, 32'h0000_0008);
        expect_rd("R1 0x140",   12'h140, 32'h0347_30E4);
        expect_rd("R1 0x144",   12'h144, 32'h0347_30E4);
        expect_rd("R1 0x008",   12'h008, 32'h0);
        expect_rd("R1 0x0D4",   12'h0D4, 32'h0);
    endtask

    task automatic t_straps;
        expect_rd("R2 strap",  12'h004, 32'hA5C3_0F17);
        expect_rd("R2 moddis", 12'h07C, 32'h0000_1230);
        strap_in = 32'hFFFF_FFFF; mod_dis_in = 32'hFFFF_FFFF;
        expect_rd("R2 strap after change",  12'h004, 32'hA5C3_0F17);
        expect_rd("R2 moddis after change", 12'h07C, 32'h0000_1230);
    endtask

    task automatic t_memfield;
        expect_rd("R3 mem cfg", 12'h09C, 32'h0000_1102);
    endtask

    task automatic t_rw;
        logic e;
        wr(12'h13C, 32'hDEAD_BEEF, e);
        chk("R4 wr err", {31'd0, e}, 32'd0);
        expect_rd("R4 scratch", 12'h13C, 32'hDEAD_BEEF);
        wr(12'h008, 32'h1357_9BDF, e);
        expect_rd("R4 0x008", 12'h008, 32'h1357_9BDF);
        wr(12'h144, 32'h0000_0001, e);
        expect_rd("R4 last word", 12'h144, 32'h0000_0001);
        expect_rd("R4 neighbour", 12'h140, 32'h0347_30E4);
    endtask

    task automatic t_ro;
        logic e;
        wr(12'h000, 32'h0, e);
        chk("R5 id err", {31'd0, e}, 32'd1);
        expect_rd("R5 id kept", 12'h000, 32'h04A9_2750);
        wr(12'h004, 32'h0, e);
        chk("R5 strap err", {31'd0, e}, 32'd1);
        expect_rd("R5 strap kept", 12'h004, 32'hA5C3_0F17);
        wr(12'h040, 32'hFFFF_FFFF, e);
        chk("R5 irq err", {31'd0, e}, 32'd1);
        expect_rd("R5 irq kept", 12'h040, 32'h0);
    endtask

    task automatic t_w1c;
        logic e;
        wr(12'h06C, 32'h7FFF_FFFF, e);
        expect_rd("R6 zero bit no clear", 12'h06C, 32'h8000_0000);
        wr(12'h06C, 32'h8000_0000, e);
        expect_rd("R6 cleared", 12'h06C, 32'h0);
        wr(12'h0D4, 32'h0000_FFFF, e);
        expect_rd("R6 host stat", 12'h0D4, 32'h0);
    endtask

    task automatic t_w1s;
        logic e;
        wr(12'h070, 32'h0000_0005, e);
        expect_rd("R7 set", 12'h070, 32'h0000_0005);
        wr(12'h070, 32'h0000_0002, e);
        expect_rd("R7 accumulate", 12'h070, 32'h0000_0007);
        wr(12'h070, 32'h0, e);
        expect_rd("R7 no clear", 12'h070, 32'h0000_0007);
        wr(12'h07C, 32'h8000_0001, e);
        expect_rd("R7 moddis", 12'h07C, 32'h8000_1231);
    endtask

    task automatic t_oor;
        logic [31:0] d;
        logic e;
        rd(12'h148, d, e);
        chk("R8 read data", d, 32'h0);
        chk("R8 read err", {31'd0, e}, 32'd1);
        wr(12'h148, 32'hFFFF_FFFF, e);
        chk("R8 write err", {31'd0, e}, 32'd1);
        expect_rd("R8 last untouched", 12'h144, 32'h0000_0001);
        expect_rd("R8 first untouched", 12'h008, 32'h1357_9BDF);
        rd(12'hFFC, d, e);
        chk("R8 top read", d, 32'h0);
    endtask

    task automatic t_misalign;
        logic [31:0] d;
        logic e;
        wr(12'h13E, 32'h0, e);
        chk("R9 write err", {31'd0, e}, 32'd1);
        expect_rd("R9 unchanged", 12'h13C, 32'hDEAD_BEEF);
        rd(12'h13D, d, e);
        chk("R9 read data", d, 32'h0);
        chk("R9 read err", {31'd0, e}, 32'd1);
    endtask

    task automatic t_ready;
        @(negedge clk);
        chk("R10 idle", {31'd0, ready}, 32'd1);
        sel = 1'b1; wr_en = 1'b0; addr = 12'h000;
        #1;
        chk("R10 access", {31'd0, ready}, 32'd1);
        @(posedge clk);
        #1;
        sel = 1'b0;
    endtask

    task automatic t_rereset;
        do_reset(32'h1234_5678, 32'h0000_0000);
        expect_rd("R2 new strap", 12'h004, 32'h1234_5678);
        expect_rd("R2 new moddis", 12'h07C, 32'h0);
        expect_rd("R7 reset clears", 12'h070, 32'h0);
        expect_rd("R1 scratch restored", 12'h13C, 32'h0000_0008);
        expect_rd("R3 mem cfg again", 12'h09C, 32'h0000_1102);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_values();
        t_straps();
        t_memfield();
        t_rw();
        t_ro();
        t_w1c();
        t_w1s();
        t_oor();
        t_misalign();
        t_ready();
        t_rereset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule